// File: doc/BRIEF.md
# Indexed Interrupt Message Controller

This block turns indexed interrupt requests into message writes. Software programs a table through a memory-mapped register window. Each vector entry in the table holds a 64-bit target address, a 32-bit payload and a per-vector mask. When a request for vector *v* is accepted and nothing blocks delivery, the block issues one outbound memory-write request. That request carries entry *v*'s address and payload, a full first-byte enable and the function's requester ID.

Delivery can be blocked in three ways: the function enable input is low, the global mask input is high, or the vector's own mask bit is set. A request that arrives while delivery is blocked is still accepted. Instead of a write, it sets the vector's bit in a pending array that software can read. Once the blocking condition clears, the pending vectors are replayed automatically, lowest index first, and each pending bit drops as its message is issued. The table and the pending array share one AXI-Lite window. The most significant address bit selects between them.

Top module: `msix_irq_ctrl`

## Requirements
- R1: Each vector owns 16 bytes of the table, which starts at window offset 0. Entry *v* begins at byte 16·v. The little-endian 64-bit message address sits at entry byte 0, the 32-bit payload at entry byte 8, and the control word at entry byte 12, whose bit 0 is the vector mask.
- R2: A table write changes only the bytes whose strobe bit is set, and bytes outside the strobe keep their old value. A read returns the stored bytes. The write response is always OKAY (bresp = 0).
- R3: Addresses with the top address bit set read the pending array as a packed vector: bit *v* of the array is bit (v mod DW) of data word v/DW. Writes to this region complete with OKAY and change nothing.
- R4: With enable high, global mask low and the vector mask clear, an accepted request produces exactly one message. The message carries the entry's address and payload, first byte enable 0xF and the current requester ID.
- R5: A request accepted while enable is low or global mask is high issues no message and sets its pending bit.
- R6: A request accepted while its vector mask is set issues no message and sets its pending bit. Unmasked vectors keep being delivered meanwhile.
- R7: When the blocking condition clears, every pending vector that is no longer masked is sent once, in ascending index order, and its pending bit returns to 0.
- R8: While the outbound port is stalled (msgValid high, msgReady low), all message fields hold their values.
- R9: Pending replays take priority: the request input is not ready while any pending vector is deliverable.
- R10: After reset the pending array and the whole table read as zero, and no message, write response or read response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Function enable |
| globalMask | input | 1 | Global mask |
| requesterId | input | 16 | Requester ID placed in each message |
| irqIndex | input | IDX_W | Requested vector index |
| irqValid | input | 1 | Request valid |
| irqReady | output | 1 | Request ready |
| axiAwAddr | input | AW | Write address |
| axiAwValid | input | 1 | Write address valid |
| axiAwReady | output | 1 | Write address ready |
| axiWData | input | DW | Write data |
| axiWStrb | input | DW/8 | Write byte strobes |
| axiWValid | input | 1 | Write data valid |
| axiWReady | output | 1 | Write data ready |
| axiBResp | output | 2 | Write response |
| axiBValid | output | 1 | Write response valid |
| axiBReady | input | 1 | Write response ready |
| axiArAddr | input | AW | Read address |
| axiArValid | input | 1 | Read address valid |
| axiArReady | output | 1 | Read address ready |
| axiRData | output | DW | Read data |
| axiRResp | output | 2 | Read response |
| axiRValid | output | 1 | Read data valid |
| axiRReady | input | 1 | Read data ready |
| msgAddr | output | 64 | Message target address |
| msgData | output | 32 | Message payload |
| msgFirstBe | output | 4 | First byte enable |
| msgRid | output | 16 | Message requester ID |
| msgValid | output | 1 | Message valid |
| msgReady | input | 1 | Message ready |

## Verification
The bench targets replay ordering after a global unmask. A design that scanned from the top, or kept releasing from a stale pointer, would emit the vectors out of order, and the per-handshake comparison would catch it. It writes the pending region while bits are set and reads it back unchanged, which exposes a region decode that lets the write through. It pends vectors against their own masks, then clears one mask at a time to confirm that only that vector is released. It offers a new request at the moment a global unmask makes old vectors deliverable, so a design that let the new request jump ahead would show up as a misordered message. Partial-strobe writes check that unselected bytes survive. Message delivery under a periodic stall checks that a message is neither lost nor duplicated while the port is held.

// File: rtl/msix_pkg.sv
package msix_pkg;
  // strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic load;       // capture a new message into the output register
    logic useReplay;  // source index is the replay pick, else the request index
  } msgCmd_t;
endpackage

// File: rtl/msix_ctrl.sv
module msix_ctrl
  import msix_pkg::*;
#(
  parameter int IDX_W = 3,
  localparam int NVEC = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             globalMask,
  input  logic [IDX_W-1:0] irqIndex,
  input  logic             irqValid,
  output logic             irqReady,
  input  logic [NVEC-1:0]  vecMask,
  input  logic             msgValid,
  input  logic             msgReady,
  output msgCmd_t          cmd,
  output logic [IDX_W-1:0] replayIdx,
  output logic [NVEC-1:0]  pba
);
  logic            slotFree;
  logic            deliverOk;
  logic [NVEC-1:0] eligible;
  logic            replayHit;
  logic            accept;
  logic            reqOk;

  assign slotFree  = !msgValid || msgReady;
  assign deliverOk = enable && !globalMask;
  assign eligible  = pba & ~vecMask & {NVEC{deliverOk}};
  assign replayHit = |eligible;

  // lowest pending deliverable vector wins
  always_comb begin
    replayIdx = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (eligible[i]) replayIdx = IDX_W'(i);
    end
  end

  assign irqReady = slotFree && !replayHit;
  assign accept   = irqValid && irqReady;
  assign reqOk    = deliverOk && !vecMask[irqIndex];

  always_comb begin
    cmd.useReplay = replayHit;
    cmd.load      = slotFree && (replayHit || (accept && reqOk));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pba <= '0;
    end else begin
      if (replayHit && slotFree) pba[replayIdx] <= 1'b0;
      if (accept && !reqOk)      pba[irqIndex]  <= 1'b1;
    end
  end
endmodule

// File: rtl/msix_regfile.sv
module msix_regfile
  import msix_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int DW    = 32,
  localparam int AW   = IDX_W + 5,
  localparam int NVEC = 1 << IDX_W,
  localparam int SB   = DW / 8,
  localparam int LSB  = $clog2(SB),
  localparam int WPE  = 16 / SB,
  localparam int TBL_WORDS = NVEC * WPE,
  localparam int WA_W = AW - 1 - LSB,
  localparam int PBA_WORDS = (NVEC + DW - 1) / DW,
  localparam int PBA_BITS  = PBA_WORDS * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      requesterId,
  input  logic [AW-1:0]    awAddr,
  input  logic             awValid,
  output logic             awReady,
  input  logic [DW-1:0]    wData,
  input  logic [SB-1:0]    wStrb,
  input  logic             wValid,
  output logic             wReady,
  output logic             bValid,
  input  logic             bReady,
  input  logic [AW-1:0]    arAddr,
  input  logic             arValid,
  output logic             arReady,
  output logic [DW-1:0]    rData,
  output logic             rValid,
  input  logic             rReady,
  input  msgCmd_t          cmd,
  input  logic [IDX_W-1:0] replayIdx,
  input  logic [IDX_W-1:0] irqIndex,
  input  logic [NVEC-1:0]  pba,
  output logic [NVEC-1:0]  vecMask,
  output logic [63:0]      msgAddr,
  output logic [31:0]      msgData,
  output logic [15:0]      msgRid,
  output logic             msgValid,
  input  logic             msgReady
);
  logic [DW-1:0]  tbl [TBL_WORDS];
  logic [127:0]   entAll [NVEC];
  logic [WA_W-1:0] wIdx, rIdx;
  logic           wrFire, rdFire;
  logic [PBA_BITS-1:0] pbaPad;
  logic [DW-1:0]  pbaRd;
  logic [IDX_W-1:0] selIdx;
  logic           unusedAddrLow;

  assign wIdx   = awAddr[AW-2:LSB];
  assign rIdx   = arAddr[AW-2:LSB];
  assign unusedAddrLow = ^{awAddr[LSB-1:0], arAddr[LSB-1:0]};
  assign wrFire = awValid && wValid && !bValid;
  assign rdFire = arValid && !rValid;
  assign awReady = wrFire;
  assign wReady  = wrFire;
  assign arReady = rdFire;

  // assemble each 16-byte entry from its table words
  always_comb begin
    for (int v = 0; v < NVEC; v++) begin
      for (int j = 0; j < WPE; j++) begin
        entAll[v][j*DW +: DW] = tbl[v*WPE + j];
      end
      vecMask[v] = entAll[v][96];
    end
  end

  assign pbaPad = PBA_BITS'(pba);
  always_comb begin
    pbaRd = '0;
    for (int w = 0; w < PBA_WORDS; w++) begin
      if (int'(rIdx) == w) pbaRd = pbaPad[w*DW +: DW];
    end
  end

  // write channel: byte-strobed table, pending region read-only
  always_ff @(posedge clk) begin
    if (rst) begin
      bValid <= 1'b0;
      for (int i = 0; i < TBL_WORDS; i++) tbl[i] <= '0;
    end else if (wrFire) begin
      bValid <= 1'b1;
      if (!awAddr[AW-1]) begin
        for (int b = 0; b < SB; b++) begin
          if (wStrb[b]) tbl[wIdx][b*8 +: 8] <= wData[b*8 +: 8];
        end
      end
    end else if (bReady) begin
      bValid <= 1'b0;
    end
  end

  // read channel
  always_ff @(posedge clk) begin
    if (rst) begin
      rValid <= 1'b0;
      rData  <= '0;
    end else if (rdFire) begin
      rValid <= 1'b1;
      rData  <= arAddr[AW-1] ? pbaRd : tbl[rIdx];
    end else if (rReady) begin
      rValid <= 1'b0;
    end
  end

  // outbound message register
  assign selIdx = cmd.useReplay ? replayIdx : irqIndex;
  always_ff @(posedge clk) begin
    if (rst) begin
      msgValid <= 1'b0;
      msgAddr  <= '0;
      msgData  <= '0;
      msgRid   <= '0;
    end else if (cmd.load) begin
      msgValid <= 1'b1;
      msgAddr  <= entAll[selIdx][63:0];
      msgData  <= entAll[selIdx][95:64];
      msgRid   <= requesterId;
    end else if (msgReady) begin
      msgValid <= 1'b0;
    end
  end
endmodule

// File: rtl/msix_irq_ctrl.sv
module msix_irq_ctrl
  import msix_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int DW    = 32,
  localparam int AW   = IDX_W + 5,
  localparam int SB   = DW / 8,
  localparam int NVEC = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             globalMask,
  input  logic [15:0]      requesterId,
  input  logic [IDX_W-1:0] irqIndex,
  input  logic             irqValid,
  output logic             irqReady,
  input  logic [AW-1:0]    axiAwAddr,
  input  logic             axiAwValid,
  output logic             axiAwReady,
  input  logic [DW-1:0]    axiWData,
  input  logic [SB-1:0]    axiWStrb,
  input  logic             axiWValid,
  output logic             axiWReady,
  output logic [1:0]       axiBResp,
  output logic             axiBValid,
  input  logic             axiBReady,
  input  logic [AW-1:0]    axiArAddr,
  input  logic             axiArValid,
  output logic             axiArReady,
  output logic [DW-1:0]    axiRData,
  output logic [1:0]       axiRResp,
  output logic             axiRValid,
  input  logic             axiRReady,
  output logic [63:0]      msgAddr,
  output logic [31:0]      msgData,
  output logic [3:0]       msgFirstBe,
  output logic [15:0]      msgRid,
  output logic             msgValid,
  input  logic             msgReady
);
  msgCmd_t          cmd;
  logic [IDX_W-1:0] replayIdx;
  logic [NVEC-1:0]  pbaBits;
  logic [NVEC-1:0]  vecMask;

  assign axiBResp   = 2'b00;
  assign axiRResp   = 2'b00;
  assign msgFirstBe = 4'hF;

  msix_ctrl #(.IDX_W(IDX_W)) ctrl (
    .clk(clk), .rst(rst), .enable(enable), .globalMask(globalMask),
    .irqIndex(irqIndex), .irqValid(irqValid), .irqReady(irqReady),
    .vecMask(vecMask), .msgValid(msgValid), .msgReady(msgReady),
    .cmd(cmd), .replayIdx(replayIdx), .pba(pbaBits)
  );

  msix_regfile #(.IDX_W(IDX_W), .DW(DW)) dp (
    .clk(clk), .rst(rst), .requesterId(requesterId),
    .awAddr(axiAwAddr), .awValid(axiAwValid), .awReady(axiAwReady),
    .wData(axiWData), .wStrb(axiWStrb), .wValid(axiWValid), .wReady(axiWReady),
    .bValid(axiBValid), .bReady(axiBReady),
    .arAddr(axiArAddr), .arValid(axiArValid), .arReady(axiArReady),
    .rData(axiRData), .rValid(axiRValid), .rReady(axiRReady),
    .cmd(cmd), .replayIdx(replayIdx), .irqIndex(irqIndex), .pba(pbaBits),
    .vecMask(vecMask), .msgAddr(msgAddr), .msgData(msgData), .msgRid(msgRid),
    .msgValid(msgValid), .msgReady(msgReady)
  );
endmodule

// File: rtl/msix_irq_ctrl_chk.sv
module msix_irq_ctrl_chk #(
  parameter int IDX_W = 3,
  parameter int DW    = 32,
  localparam int NVEC = 1 << IDX_W
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             globalMask,
  input logic [IDX_W-1:0] irqIndex,
  input logic             irqValid,
  input logic             irqReady,
  input logic [NVEC-1:0]  pbaBits,
  input logic [NVEC-1:0]  vecMask,
  input logic             axiBValid,
  input logic             axiBReady,
  input logic             axiRValid,
  input logic             axiRReady,
  input logic [DW-1:0]    axiRData,
  input logic [63:0]      msgAddr,
  input logic [31:0]      msgData,
  input logic [15:0]      msgRid,
  input logic             msgValid,
  input logic             msgReady
);
  assert_msg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    msgValid && !msgReady |=> msgValid && $stable(msgAddr) && $stable(msgData) && $stable(msgRid));

  assert_no_msg_blocked_R5: assert property (@(posedge clk) disable iff (rst)
    (!msgValid || msgReady) && (!enable || globalMask) |=> !msgValid);

  assert_pend_on_mask_R5: assert property (@(posedge clk) disable iff (rst)
    irqValid && irqReady && globalMask |=> pbaBits[$past(irqIndex)]);

  assert_pend_on_vecmask_R6: assert property (@(posedge clk) disable iff (rst)
    irqValid && irqReady && vecMask[irqIndex] |=> pbaBits[$past(irqIndex)]);

  assert_replay_first_R9: assert property (@(posedge clk) disable iff (rst)
    irqReady && enable && !globalMask |-> (pbaBits & ~vecMask) == '0);

  assert_bresp_hold_R2: assert property (@(posedge clk) disable iff (rst)
    axiBValid && !axiBReady |=> axiBValid);

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    axiRValid && !axiRReady |=> axiRValid && $stable(axiRData));
endmodule

bind msix_irq_ctrl msix_irq_ctrl_chk #(.IDX_W(IDX_W), .DW(DW)) chk (
  .clk(clk), .rst(rst), .enable(enable), .globalMask(globalMask),
  .irqIndex(irqIndex), .irqValid(irqValid), .irqReady(irqReady),
  .pbaBits(pbaBits), .vecMask(vecMask),
  .axiBValid(axiBValid), .axiBReady(axiBReady),
  .axiRValid(axiRValid), .axiRReady(axiRReady), .axiRData(axiRData),
  .msgAddr(msgAddr), .msgData(msgData), .msgRid(msgRid),
  .msgValid(msgValid), .msgReady(msgReady)
);

// File: tb/msix_irq_ctrl_test.sv
`timescale 1ns/1ps
module msix_irq_ctrl_test;
  localparam int IDX_W = 3;
  localparam int DW    = 32;
  localparam int AW    = IDX_W + 5;
  localparam int NVEC  = 1 << IDX_W;
  localparam logic [AW-1:0] PBA_BASE = AW'(1) << (AW - 1);

  logic clk = 0, rst = 1;
  logic enable = 0, globalMask = 0;
  logic [15:0] requesterId = 16'hBEEF;
  logic [IDX_W-1:0] irqIndex = '0;
  logic irqValid = 0, irqReady;
  logic [AW-1:0] axiAwAddr = '0, axiArAddr = '0;
  logic axiAwValid = 0, axiAwReady, axiWValid = 0, axiWReady;
  logic [DW-1:0] axiWData = '0, axiRData;
  logic [3:0] axiWStrb = '0;
  logic [1:0] axiBResp, axiRResp;
  logic axiBValid, axiBReady = 1, axiArValid = 0, axiArReady, axiRValid, axiRReady = 1;
  logic [63:0] msgAddr;
  logic [31:0] msgData;
  logic [3:0] msgFirstBe;
  logic [15:0] msgRid;
  logic msgValid, msgReady = 1;

  int checks = 0, fails = 0;
  logic [7:0] tblM [NVEC*16];
  logic [NVEC-1:0] pbaM = '0;
  int expQ[$];
  bit stall = 0;

  always #10 clk = ~clk;

  msix_irq_ctrl #(.IDX_W(IDX_W), .DW(DW)) uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic ctrlBit(int v);
    return tblM[v*16 + 12][0];
  endfunction

  // outbound stall pattern: ready one cycle in three
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      cnt++;
      msgReady = stall ? (cnt % 3 == 0) : 1'b1;
    end
  end

  // reference model: request acceptance and message comparison
  always @(negedge clk) begin
    if (!rst) begin
      if (irqValid && irqReady) begin
        if (enable && !globalMask && !ctrlBit(int'(irqIndex))) expQ.push_back(int'(irqIndex));
        else pbaM[irqIndex] = 1'b1;
      end
      if (msgValid && msgReady) begin
        if (expQ.size() == 0) begin
          check("R4 unexpected message", msgAddr, 64'hX);
        end else begin
          int v;
          logic [63:0] ea;
          logic [31:0] ed;
          v = expQ.pop_front();
          for (int b = 0; b < 8; b++) ea[b*8 +: 8] = tblM[v*16 + b];
          for (int b = 0; b < 4; b++) ed[b*8 +: 8] = tblM[v*16 + 8 + b];
          check("R4/R7 msg addr", msgAddr, ea);
          check("R4/R7 msg data", {32'h0, msgData}, {32'h0, ed});
          check("R4 first byte enable", {60'h0, msgFirstBe}, 64'hF);
          check("R4 requester id", {48'h0, msgRid}, {48'h0, requesterId});
        end
      end
    end
  end

  task automatic releaseModel();
    if (enable && !globalMask) begin
      for (int v = 0; v < NVEC; v++) begin
        if (pbaM[v] && !ctrlBit(v)) begin
          expQ.push_back(v);
          pbaM[v] = 1'b0;
        end
      end
    end
  endtask

  task automatic axiWrite(logic [AW-1:0] a, logic [31:0] d, logic [3:0] s, output logic [1:0] resp);
    axiAwAddr = a; axiWData = d; axiWStrb = s; axiAwValid = 1; axiWValid = 1;
    do @(negedge clk); while (!axiAwReady);
    @(posedge clk); #1;
    axiAwValid = 0; axiWValid = 0;
    if (!a[AW-1]) begin
      for (int b = 0; b < 4; b++)
        if (s[b]) tblM[int'({a[AW-2:2], 2'b00}) + b] = d[b*8 +: 8];
    end
    do @(negedge clk); while (!axiBValid);
    resp = axiBResp;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    logic [1:0] r;
    axiWrite(a, d, 4'hF, r);
  endtask

  task automatic axiRead(logic [AW-1:0] a, output logic [31:0] d);
    axiArAddr = a; axiArValid = 1;
    do @(negedge clk); while (!axiArReady);
    @(posedge clk); #1;
    axiArValid = 0;
    do @(negedge clk); while (!axiRValid);
    d = axiRData;
    @(posedge clk); #1;
  endtask

  task automatic sendIrq(int idx);
    irqIndex = IDX_W'(idx); irqValid = 1;
    do @(negedge clk); while (!irqReady);
    @(posedge clk); #1;
    irqValid = 0;
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 400 && expQ.size() != 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
    check(req, 64'(expQ.size()), 64'd0);
  endtask

  task automatic expectPba(string req, logic [31:0] exp);
    logic [31:0] d;
    axiRead(PBA_BASE, d);
    check(req, {32'h0, d}, {32'h0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [1:0] r;
    for (int i = 0; i < NVEC*16; i++) tblM[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R10 msgValid after reset", {63'h0, msgValid}, 64'd0);
    check("R10 bValid after reset", {63'h0, axiBValid}, 64'd0);
    check("R10 rValid after reset", {63'h0, axiRValid}, 64'd0);
    @(posedge clk); #1;
    expectPba("R10 pending zero after reset", 32'h0);
    axiRead(AW'(16*5 + 8), d);
    check("R10 table zero after reset", {32'h0, d}, 64'h0);

    // program table (R1)
    for (int k = 0; k < NVEC; k++) begin
      wr(AW'(k*16 + 0), 32'h1000_0000 + 32'(k*4));
      wr(AW'(k*16 + 4), 32'h1234_5678);
      wr(AW'(k*16 + 8), 32'h0000_D000 + 32'(k));
      wr(AW'(k*16 + 12), 32'h0);
    end
    axiRead(AW'(3*16 + 4), d);
    check("R1 addr high word readback", {32'h0, d}, 64'h1234_5678);

    // partial strobes (R2)
    wr(AW'(7*16 + 8), 32'hAABB_CCDD);
    axiWrite(AW'(7*16 + 8), 32'h1122_3344, 4'b0110, r);
    check("R2 write response okay", {62'h0, r}, 64'd0);
    axiRead(AW'(7*16 + 8), d);
    check("R2 strobe merge", {32'h0, d}, 64'hAA22_33DD);
    axiWrite(AW'(7*16 + 12), 32'hFFFF_FF00, 4'b1000, r);
    axiRead(AW'(7*16 + 12), d);
    check("R2 top byte only, mask bit untouched", {32'h0, d}, 64'hFF00_0000);

    // unmasked delivery under stall (R4, R8)
    enable = 1;
    stall = 1;
    for (int k = 0; k < NVEC; k++) sendIrq(k);
    drain("R4/R8 all delivered under stall");
    stall = 0;

    // global mask pends, then replay ascending (R5, R7)
    globalMask = 1;
    sendIrq(6); sendIrq(1); sendIrq(3);
    repeat (6) @(posedge clk); #1;
    check("R5 no message while masked", 64'(expQ.size()), 64'd0);
    expectPba("R5 pending set", 32'h4A);
    globalMask = 0;
    releaseModel();
    drain("R7 replay of global mask");
    expectPba("R7 pending cleared", 32'h0);

    // disabled function pends (R5)
    enable = 0;
    sendIrq(5);
    repeat (3) @(posedge clk); #1;
    expectPba("R5 pending while disabled", 32'h20);
    enable = 1;
    releaseModel();
    drain("R5 delivered after enable");

    // per-vector masks (R6, R3, R7)
    wr(AW'(2*16 + 12), 32'h1);
    wr(AW'(4*16 + 12), 32'h1);
    sendIrq(4); sendIrq(2); sendIrq(0);
    drain("R6 unmasked vector still delivered");
    expectPba("R6 masked vectors pending", 32'h14);
    axiWrite(PBA_BASE, 32'h0, 4'hF, r);
    check("R3 pending write okay", {62'h0, r}, 64'd0);
    expectPba("R3 pending write ignored", 32'h14);
    wr(AW'(4*16 + 12), 32'h0);
    releaseModel();
    drain("R7 vector 4 replay");
    expectPba("R7 only vector 2 left", 32'h04);
    wr(AW'(2*16 + 12), 32'h0);
    releaseModel();
    drain("R7 vector 2 replay");

    // replay priority over a new request (R9)
    globalMask = 1;
    sendIrq(2); sendIrq(0); sendIrq(1);
    globalMask = 0;
    releaseModel();
    irqIndex = 3'd5; irqValid = 1;
    @(negedge clk);
    check("R9 request blocked during replay", {63'h0, irqReady}, 64'd0);
    do @(negedge clk); while (!irqReady);
    @(posedge clk); #1;
    irqValid = 0;
    drain("R9 replays then new request");
    expectPba("R9 pending clear", 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule